// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a clocked single-port static memory that keeps its data bus busy on every cycle. A command is a chip enable, a write flag and an address, all taken at a rising clock edge. Read and write data use the same slot on the bus: both fall two edges after their command. A read's data comes out of an output register two edges after the command. A write's data is expected on the write-data input in the cycle just before the second edge after its command. Because both directions use the same spacing, commands of either type can follow each other on every cycle and no cycle is lost to bus turnaround.

Each command moves through a two-stage slot pipeline. The slot state of a stage is IDLE, READ or WRITE. The first stage takes its state from the inputs at each edge: enable low goes to IDLE, enable high with the write flag low goes to READ, and enable high with the write flag high goes to WRITE. The second stage copies the first stage at every edge. When the first stage holds READ, the array is read at the next edge into a read register. When the second stage holds WRITE, the write-data input is stored at the second stage's address at that same edge. If both of these happen at one edge and the addresses match, the read takes the incoming write data instead of the stale array word. At the edge after the second stage holds READ, the output register loads the read register and the drive-enable output rises for one cycle.

Top module: `zbt_sram_core`

## Requirements
- R1: Every location keeps its own word. After distinct values are written to all 2^AW addresses, reading each address returns the value written to that address.
- R2: For a write command sampled at edge k, the value on `wr_data` at edge k+2 is stored at that command's address.
- R3: For a read command sampled at edge k, `rd_data` changes at edge k+2 and `rd_drive` is 1 for exactly the cycle that follows edge k+2.
- R4: `rd_drive` is 0 in every cycle whose data slot belongs to a write command.
- R5: A read issued one or two cycles after a write to the same address returns the new data.
- R6: When `cmd_en` is low, the cycle is a no-op whatever the values of `cmd_wr` and `wr_data`. `rd_drive` is 0 in its data slot, `rd_data` keeps its previous value, and no location changes.
- R7: After reset, `rd_drive` is 0 and `rd_data` is all zeros.
- R8: A random mix of reads, writes and idle cycles, issued one per cycle with no wait cycles, returns the correct data for every read.
- R9: `wr_data` is ignored in any cycle that is not the data slot of a write. Junk driven there changes no location.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all activity on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_en | input | 1 | Command enable; high means a command is issued this edge |
| cmd_wr | input | 1 | 1 for a write command, 0 for a read |
| cmd_addr | input | AW | Command address |
| wr_data | input | DW | Write data, sampled two edges after its write command |
| rd_data | output | DW | Registered read data |
| rd_drive | output | 1 | High in the cycle in which `rd_data` carries a read result |

## Verification
The first pattern fills every address with a different value and then reads all of them back. This separates address mix-ups from data faults. Directed pairs put a read one or two cycles behind a write to the same address. These show whether forwarding from the write in flight works, as opposed to plain array reads. Disabled cycles are driven with the write flag high and junk write data, and a later read of the target address shows whether any of them leaked into the array. A long random stream mixes reads, writes and idle slots over a narrow address range and over the full range. This catches slot-spacing errors that appear only when the command types alternate back to back.

// File: rtl/zbt_sram_pkg.sv
package zbt_sram_pkg;

    // Spacing in edges between a command and its data slot on the bus.
    localparam int unsigned BUS_LAT = 2;

    typedef enum logic [1:0] {
        SLOT_IDLE  = 2'd0,
        SLOT_READ  = 2'd1,
        SLOT_WRITE = 2'd2
    } slot_e;

endpackage

// File: rtl/zbt_cmd_pipe.sv
module zbt_cmd_pipe
    import zbt_sram_pkg::*;
#(
    parameter int unsigned AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_en,
    input  logic          cmd_wr,
    input  logic [AW-1:0] cmd_addr,
    output slot_e         s1_slot,
    output logic [AW-1:0] s1_addr,
    output slot_e         s2_slot,
    output logic [AW-1:0] s2_addr
);

    localparam int unsigned LAST = BUS_LAT - 1;

    slot_e         slot_q [BUS_LAT];
    logic [AW-1:0] addr_q [BUS_LAT];
    slot_e         slot_d;

    // next state of the entry stage, chosen from the sampled command
    always_comb begin
        unique case ({cmd_en, cmd_wr})
            2'b10:   slot_d = SLOT_READ;
            2'b11:   slot_d = SLOT_WRITE;
            default: slot_d = SLOT_IDLE;
        endcase
    end

    // state register: every stage advances each edge, idle or not
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < BUS_LAT; i++) begin
                slot_q[i] <= SLOT_IDLE;
                addr_q[i] <= '0;
            end
        end else begin
            slot_q[0] <= slot_d;
            addr_q[0] <= cmd_addr;
            for (int i = 1; i < BUS_LAT; i++) begin
                slot_q[i] <= slot_q[i-1];
                addr_q[i] <= addr_q[i-1];
            end
        end
    end

    assign s1_slot = slot_q[0];
    assign s1_addr = addr_q[0];
    assign s2_slot = slot_q[LAST];
    assign s2_addr = addr_q[LAST];

endmodule

// File: rtl/zbt_array.sv
module zbt_array
    import zbt_sram_pkg::*;
#(
    parameter int unsigned AW = 6,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  slot_e         rd_slot,
    input  logic [AW-1:0] rd_addr,
    input  slot_e         wr_slot,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_word
);

    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic          wr_hit;

    // write in flight at this very edge targets the word being read
    assign wr_hit = (wr_slot == SLOT_WRITE) && (rd_slot == SLOT_READ)
                    && (wr_addr == rd_addr);

    always_ff @(posedge clk) begin
        if (wr_slot == SLOT_WRITE) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_word <= '0;
        end else if (rd_slot == SLOT_READ) begin
            rd_word <= wr_hit ? wr_data : mem[rd_addr];
        end
    end

endmodule

// File: rtl/zbt_out_stage.sv
module zbt_out_stage
    import zbt_sram_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  slot_e         slot,
    input  logic [DW-1:0] rd_word,
    output logic [DW-1:0] rd_data,
    output logic          rd_drive
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_drive <= 1'b0;
        end else begin
            rd_drive <= (slot == SLOT_READ);
            if (slot == SLOT_READ) begin
                rd_data <= rd_word;
            end
        end
    end

    AST_DRIVE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_READ) |=> rd_drive); // R3

    AST_DATA_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_drive |-> $stable(rd_data)); // R6

endmodule

// File: rtl/zbt_sram_core.sv
module zbt_sram_core
    import zbt_sram_pkg::*;
#(
    parameter int unsigned AW = 6,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_en,
    input  logic          cmd_wr,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic          rd_drive
);

    slot_e         s1_slot;
    slot_e         s2_slot;
    logic [AW-1:0] s1_addr;
    logic [AW-1:0] s2_addr;
    logic [DW-1:0] rd_word;

    zbt_cmd_pipe #(.AW(AW)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_en   (cmd_en),
        .cmd_wr   (cmd_wr),
        .cmd_addr (cmd_addr),
        .s1_slot  (s1_slot),
        .s1_addr  (s1_addr),
        .s2_slot  (s2_slot),
        .s2_addr  (s2_addr)
    );

    zbt_array #(.AW(AW), .DW(DW)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_slot (s1_slot),
        .rd_addr (s1_addr),
        .wr_slot (s2_slot),
        .wr_addr (s2_addr),
        .wr_data (wr_data),
        .rd_word (rd_word)
    );

    zbt_out_stage #(.DW(DW)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot     (s2_slot),
        .rd_word  (rd_word),
        .rd_data  (rd_data),
        .rd_drive (rd_drive)
    );

    AST_WRITE_TRACKS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_slot == SLOT_WRITE) |-> $past(cmd_en && cmd_wr, 2)); // R2

    AST_DRIVE_ONLY_FOR_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_drive |-> $past(cmd_en && !cmd_wr, 3)); // R4

endmodule

// File: tb/zbt_sram_core_test.sv
`timescale 1ns/1ps
module zbt_sram_core_test;

    localparam int AW    = 6;
    localparam int DW    = 16;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_en = 1'b0;
    logic          cmd_wr = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          rd_drive;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] model [DEPTH];
    logic [DW-1:0] last_rd = '0;
    bit            h_rd  [0:2];
    bit            h_wr  [0:2];
    int            h_addr[0:2];
    string         h_tag [0:2];

    zbt_sram_core #(.AW(AW), .DW(DW)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_en   (cmd_en),
        .cmd_wr   (cmd_wr),
        .cmd_addr (cmd_addr),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .rd_drive (rd_drive)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] expect_word(input int a);
        return model[a];
    endfunction

    // One clock: check the data slot of the command two edges back,
    // drive the write data for the command one edge back, issue a new one.
    task automatic cycle(input bit en, input bit wr, input int addr, input string tag);
        string t;
        logic [DW-1:0] wd;
        @(negedge clk);
        if (h_rd[2]) begin
            chk(rd_drive == 1'b1, "R3", int'(rd_drive), 1);
            chk(rd_data == expect_word(h_addr[2]), h_tag[2],
                int'(rd_data), int'(expect_word(h_addr[2])));
            last_rd = rd_data;
        end else begin
            t = h_wr[2] ? "R4" : "R6";
            chk(rd_drive == 1'b0, t, int'(rd_drive), 0);
            chk(rd_data == last_rd, t, int'(rd_data), int'(last_rd));
        end
        wd = DW'($urandom);
        if (h_wr[1]) model[h_addr[1]] = wd;   // R2: value in the slot is stored
        wr_data = wd;                          // otherwise junk (R9)
        t = tag;
        if (t == "") t = (h_wr[0] && h_addr[0] == addr) ? "R5" : "R8";
        cmd_en   = en;
        cmd_wr   = wr;
        cmd_addr = AW'(addr);
        for (int i = 2; i > 0; i--) begin
            h_rd[i] = h_rd[i-1]; h_wr[i] = h_wr[i-1];
            h_addr[i] = h_addr[i-1]; h_tag[i] = h_tag[i-1];
        end
        h_rd[0] = en && !wr;
        h_wr[0] = en && wr;
        h_addr[0] = addr;
        h_tag[0] = t;
    endtask

    initial begin
        #(20ns * 200000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 3; i++) begin
            h_rd[i] = 0; h_wr[i] = 0; h_addr[i] = 0; h_tag[i] = "R7";
        end
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R7: reset state at the ports
        chk(rd_drive == 1'b0, "R7", int'(rd_drive), 0);
        chk(rd_data == '0, "R7", int'(rd_data), 0);

        // R1: fill every address, then read them all back
        for (int a = 0; a < DEPTH; a++) cycle(1, 1, a, "R2");
        for (int a = 0; a < DEPTH; a++) cycle(1, 0, a, "R1");

        // R5: read right behind a write, and one idle cycle behind
        cycle(1, 1, 5, "");
        cycle(1, 0, 5, "R5");
        cycle(1, 1, 6, "");
        cycle(0, 0, 0, "");
        cycle(1, 0, 6, "R5");
        cycle(1, 1, 9, "");
        cycle(1, 1, 9, "");
        cycle(1, 0, 9, "R5");

        // R6: disabled cycles with the write flag high change nothing
        cycle(0, 1, 7, "");
        cycle(0, 1, 7, "");
        cycle(0, 1, 7, "");
        cycle(1, 0, 7, "R6");

        // R9: junk on wr_data outside write slots
        cycle(1, 1, 12, "");
        cycle(0, 1, 12, "");
        cycle(1, 0, 13, "");
        cycle(0, 0, 12, "");
        cycle(1, 0, 14, "");
        cycle(1, 0, 12, "R9");

        // R8: random back-to-back mix
        for (int n = 0; n < 3000; n++) begin
            bit en = ($urandom % 4) != 0;
            bit wr = $urandom % 2;
            int a  = (n % 2 == 0) ? int'($urandom % 4) : int'($urandom % DEPTH);
            cycle(en, wr, a, "");
        end
        repeat (3) cycle(0, 0, 0, "");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule